// File: doc/BRIEF.md
# UART Receive Character Queue with Fill-Level Interrupt

This block holds received characters for a UART until software reads them through the data register. Each slot stores an 8-bit character, a 3-bit error field and a break marker. Characters come from one of two producers. The serial receive path is the normal one. A loopback path is used while the port is wired back to itself. The block shows full and empty flags and a free-slot count, so the upstream producer can hold off when no space is left. It raises a receive interrupt level at exact fill-level crossings against a trigger level.

A mode input picks the queue length. When it is high the queue is a 16-entry FIFO. When it is low the queue is a single holding register. Every change of this input empties the queue. A read of the data register pops the head entry. It also copies that entry's error and break bits into a sticky status register, which software clears by writing it. A separate 6-bit level-select register is kept for the bus side; it does not change the trigger.

The controller is a three-state machine: `Q_EMPTY`, `Q_PART` (some entries, not full) and `Q_FULL`. The transitions are:
- FILL_FIRST: `Q_EMPTY` to `Q_PART`, or to `Q_FULL` in single-register mode.
- FILL_LAST: `Q_PART` to `Q_FULL`.
- DRAIN_ONE: `Q_FULL` to `Q_PART`.
- DRAIN_LAST: to `Q_EMPTY` when the count returns to zero.
- FLUSH: any state to `Q_EMPTY` on a mode change.

Top module: `uart_rxq`

## Requirements
- R1: After reset the queue is empty, full is 0, rx_irq is 0, the status register is zero, and the internal mode is single-register, so free_cnt is 1 while fifo_en is held low.
- R2: With fifo_en high the queue holds 16 entries. Entries pop in push order with data, err and brk intact. free_cnt always equals the effective depth minus the stored count. full is 1 exactly when the count equals the effective depth.
- R3: A push arriving while full is dropped. The stored entries, full and free_cnt stay as they were.
- R4: With fifo_en low the effective depth is 1. One push sets full and makes free_cnt 0. One pop returns to empty with free_cnt 1.
- R5: In the first cycle that fifo_en differs from the mode in use, the queue is flushed. The count and read pointer go to zero, full goes to 0 and empty to 1. Any push or pop in that cycle is ignored. rx_irq keeps its level. From the next cycle the new depth applies.
- R6: rx_irq is set by an accepted push, with no accepted pop in the same cycle, that leaves the count equal to the trigger level (1 by default).
- R7: rx_irq is cleared by a pop request, with no accepted push in the same cycle, after which count + 1 equals the trigger level. This includes a pop on an empty queue.
- R8: A pop on an empty queue changes no count, pointer or flag.
- R9: Every pop request outside a flush cycle loads stat_err and stat_brk from the head entry. stat_clr zeroes them. When both happen in one cycle, the pop wins.
- R10: A line break is pushed with brk = 1. It keeps that bit through the queue and into the status register.
- R11: While lb_en is 1, only lb_push/lb_data/lb_brk can write, and such entries carry err = 0. The serial push is ignored.
- R12: lvl_sel resets to 0x12. A write with lvl_wr loads lvl_wdata.
- R13: A push and a pop accepted in the same cycle leave the count, full, empty and rx_irq unchanged, and the pushed entry still joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1: 16-entry FIFO, 0: single holding register |
| lb_en | input | 1 | Select the loopback producer |
| ser_push | input | 1 | Serial path push strobe |
| ser_data | input | 8 | Serial character |
| ser_err | input | 3 | Serial error bits |
| ser_brk | input | 1 | Serial line-break marker |
| lb_push | input | 1 | Loopback push strobe |
| lb_data | input | 8 | Loopback character |
| lb_brk | input | 1 | Loopback break marker |
| pop | input | 1 | Data-register read strobe |
| pop_data | output | 8 | Head entry character |
| pop_err | output | 3 | Head entry error bits |
| pop_brk | output | 1 | Head entry break marker |
| full | output | 1 | Queue full |
| empty | output | 1 | Queue empty |
| free_cnt | output | 5 | Free slots for the producer |
| rx_irq | output | 1 | Receive interrupt level |
| stat_clr | input | 1 | Status register write (clears it) |
| stat_err | output | 3 | Latched error bits of last pop |
| stat_brk | output | 1 | Latched break bit of last pop |
| lvl_wr | input | 1 | Level-select register write |
| lvl_wdata | input | 6 | Level-select write data |
| lvl_sel | output | 6 | Level-select register value |

## Verification
The bench fills the 16-entry queue to the brim and then pushes once more. A design that let the count wrap would overwrite the head and show a wrong free count. It flushes a queue while the interrupt is high and then pops the empty queue. A design that cleared the level on flush, or ignored empty pops, would leave rx_irq wrong at one of those two steps. A simultaneous push and pop on a one-entry queue catches a count or interrupt that moves when it should hold. A loopback push with the serial error lines driven exposes a producer select that leaks the serial fields or accepts the serial strobe.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int RXQ_DATA_W = 8;
    localparam int RXQ_ERR_W  = 3;

    typedef struct packed {
        logic                  brk;
        logic [RXQ_ERR_W-1:0]  err;
        logic [RXQ_DATA_W-1:0] data;
    } rxq_entry_t;

    typedef enum logic [1:0] {
        Q_EMPTY = 2'd0,
        Q_PART  = 2'd1,
        Q_FULL  = 2'd2
    } rxq_state_t;
endpackage

// File: rtl/rxq_src_sel.sv
module rxq_src_sel
    import rxq_pkg::*;
(
    input  logic                  lb_en,
    input  logic                  ser_push,
    input  rxq_entry_t            ser_entry,
    input  logic                  lb_push,
    input  logic [RXQ_DATA_W-1:0] lb_data,
    input  logic                  lb_brk,
    output logic                  req,
    output rxq_entry_t            entry
);
    always_comb begin
        if (lb_en) begin
            req        = lb_push;
            entry.brk  = lb_brk;
            entry.err  = '0;
            entry.data = lb_data;
        end else begin
            req   = ser_push;
            entry = ser_entry;
        end
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  rxq_entry_t       wdata,
    input  logic [PTR_W-1:0] raddr,
    output rxq_entry_t       rdata
);
    rxq_entry_t slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[i] <= '0;
            else if (we && waddr == PTR_W'(i))
                slot_q[i] <= wdata;
        end
    end

    assign rdata = slot_q[raddr];
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int RX_TRIG = 1,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             wr_req,
    input  logic             rd_req,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [PTR_W-1:0] rd_addr,
    output logic             rd_take,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] free_cnt,
    output logic             irq,
    output logic             mode_q
);
    localparam logic [CNT_W:0] TRIG_V = (CNT_W+1)'(RX_TRIG);

    rxq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, depth_eff;
    logic [PTR_W-1:0] rd_q, rd_d, mask;
    logic             irq_q, irq_d;
    logic             mode_chg, push_ok, pop_ok, pop_any;

    assign mode_chg  = (fifo_en != mode_q);
    assign depth_eff = mode_q ? CNT_W'(DEPTH) : CNT_W'(1);
    assign mask      = mode_q ? PTR_W'(DEPTH - 1) : '0;
    assign push_ok   = wr_req && !mode_chg && (state_q != Q_FULL);
    assign pop_any   = rd_req && !mode_chg;
    assign pop_ok    = pop_any && (state_q != Q_EMPTY);

    // Next count, pointer and interrupt level
    always_comb begin
        cnt_d = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
        rd_d  = pop_ok ? ((rd_q + PTR_W'(1)) & mask) : rd_q;
        irq_d = irq_q;
        if (pop_any && !push_ok && ({1'b0, cnt_d} + 1'b1) == TRIG_V)
            irq_d = 1'b0;
        else if (push_ok && !pop_ok && {1'b0, cnt_d} == TRIG_V)
            irq_d = 1'b1;
        if (mode_chg) begin
            cnt_d = '0;
            rd_d  = '0;
        end
    end

    // Next state: FLUSH, FILL_FIRST, FILL_LAST, DRAIN_ONE, DRAIN_LAST
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            Q_EMPTY: if (cnt_d == depth_eff)   state_d = Q_FULL;
                     else if (cnt_d != '0)     state_d = Q_PART;
            Q_PART:  if (cnt_d == '0)          state_d = Q_EMPTY;
                     else if (cnt_d == depth_eff) state_d = Q_FULL;
            Q_FULL:  if (cnt_d == '0)          state_d = Q_EMPTY;
                     else if (cnt_d != depth_eff) state_d = Q_PART;
            default:                           state_d = Q_EMPTY;
        endcase
        if (mode_chg) state_d = Q_EMPTY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= Q_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rd_q   <= '0;
            irq_q  <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            rd_q   <= rd_d;
            irq_q  <= irq_d;
            mode_q <= fifo_en;
        end
    end

    // Outputs
    always_comb begin
        full     = 1'b0;
        empty    = 1'b0;
        unique case (state_q)
            Q_EMPTY: empty = 1'b1;
            Q_FULL:  full  = 1'b1;
            default: ;
        endcase
        free_cnt = depth_eff - cnt_q;
        wr_en    = push_ok;
        wr_addr  = (rd_q + cnt_q[PTR_W-1:0]) & mask;
        rd_addr  = rd_q;
        rd_take  = pop_any;
        irq      = irq_q;
    end
endmodule

// File: rtl/rxq_stat.sv
module rxq_stat
    import rxq_pkg::*;
#(
    parameter int LVL_W = 6,
    parameter logic [LVL_W-1:0] LVL_RESET = 6'h12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  rxq_entry_t           head,
    input  logic                 clr,
    input  logic                 lvl_wr,
    input  logic [LVL_W-1:0]     lvl_wdata,
    output logic [RXQ_ERR_W-1:0] stat_err,
    output logic                 stat_brk,
    output logic [LVL_W-1:0]     lvl_sel
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_err <= '0;
            stat_brk <= 1'b0;
        end else if (take) begin
            stat_err <= head.err;
            stat_brk <= head.brk;
        end else if (clr) begin
            stat_err <= '0;
            stat_brk <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lvl_sel <= LVL_RESET;
        else if (lvl_wr) lvl_sel <= lvl_wdata;
    end
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
    import rxq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int RX_TRIG = 1,
    parameter int LVL_W   = 6,
    parameter logic [LVL_W-1:0] LVL_RESET = 6'h12,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fifo_en,
    input  logic                  lb_en,
    input  logic                  ser_push,
    input  logic [RXQ_DATA_W-1:0] ser_data,
    input  logic [RXQ_ERR_W-1:0]  ser_err,
    input  logic                  ser_brk,
    input  logic                  lb_push,
    input  logic [RXQ_DATA_W-1:0] lb_data,
    input  logic                  lb_brk,
    input  logic                  pop,
    output logic [RXQ_DATA_W-1:0] pop_data,
    output logic [RXQ_ERR_W-1:0]  pop_err,
    output logic                  pop_brk,
    output logic                  full,
    output logic                  empty,
    output logic [CNT_W-1:0]      free_cnt,
    output logic                  rx_irq,
    input  logic                  stat_clr,
    output logic [RXQ_ERR_W-1:0]  stat_err,
    output logic                  stat_brk,
    input  logic                  lvl_wr,
    input  logic [LVL_W-1:0]      lvl_wdata,
    output logic [LVL_W-1:0]      lvl_sel
);
    rxq_entry_t       ser_entry, in_entry, head;
    logic             in_req, wr_en, rd_take, mode_q;
    logic [PTR_W-1:0] wr_addr, rd_addr;

    assign ser_entry = '{brk: ser_brk, err: ser_err, data: ser_data};

    rxq_src_sel u_src (
        .lb_en(lb_en), .ser_push(ser_push), .ser_entry(ser_entry),
        .lb_push(lb_push), .lb_data(lb_data), .lb_brk(lb_brk),
        .req(in_req), .entry(in_entry)
    );

    rxq_ctrl #(.DEPTH(DEPTH), .RX_TRIG(RX_TRIG)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
        .wr_req(in_req), .rd_req(pop),
        .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_take(rd_take),
        .full(full), .empty(empty), .free_cnt(free_cnt), .irq(rx_irq),
        .mode_q(mode_q)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(wr_addr),
        .wdata(in_entry), .raddr(rd_addr), .rdata(head)
    );

    rxq_stat #(.LVL_W(LVL_W), .LVL_RESET(LVL_RESET)) u_stat (
        .clk(clk), .rst_n(rst_n), .take(rd_take), .head(head), .clr(stat_clr),
        .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata),
        .stat_err(stat_err), .stat_brk(stat_brk), .lvl_sel(lvl_sel)
    );

    assign pop_data = head.data;
    assign pop_err  = head.err;
    assign pop_brk  = head.brk;
endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fifo_en,
    input logic             mode_q,
    input logic             lb_en,
    input logic             ser_push,
    input logic             lb_push,
    input logic             pop,
    input logic             full,
    input logic             empty,
    input logic [CNT_W-1:0] free_cnt,
    input logic             rx_irq,
    input logic             stat_clr,
    input logic [2:0]       stat_err,
    input logic             stat_brk
);
    logic push_req;
    assign push_req = lb_en ? lb_push : ser_push;

    p_free_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> free_cnt == '0);
    p_free_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> free_cnt == (mode_q ? CNT_W'(DEPTH) : CNT_W'(1)));
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_req && !pop && fifo_en == mode_q) |=> (full && free_cnt == '0));
    p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> free_cnt <= CNT_W'(1));
    p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != mode_q) |=> (empty && !full));
    p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> $past(push_req));
    p_irq_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_irq) |-> $past(pop));
    p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push_req && fifo_en == mode_q) |=> (empty && $stable(free_cnt)));
    p_stat_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !pop) |=> (stat_err == 3'd0 && !stat_brk));
endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .mode_q(mode_q),
    .lb_en(lb_en), .ser_push(ser_push), .lb_push(lb_push), .pop(pop),
    .full(full), .empty(empty), .free_cnt(free_cnt), .rx_irq(rx_irq),
    .stat_clr(stat_clr), .stat_err(stat_err), .stat_brk(stat_brk)
);

// File: tb/uart_rxq_tb.sv
`timescale 1ns/1ps
module uart_rxq_tb;
    localparam int DEPTH = 16;
    localparam int TRIG  = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_en = 0, lb_en = 0, ser_push = 0, ser_brk = 0, lb_push = 0, lb_brk = 0;
    logic pop = 0, stat_clr = 0, lvl_wr = 0;
    logic [7:0] ser_data = 0, lb_data = 0;
    logic [2:0] ser_err = 0;
    logic [5:0] lvl_wdata = 0;
    logic [7:0] pop_data;
    logic [2:0] pop_err, stat_err;
    logic pop_brk, full, empty, rx_irq, stat_brk;
    logic [4:0] free_cnt;
    logic [5:0] lvl_sel;

    always #2.5 clk = ~clk;

    uart_rxq u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .lb_en(lb_en),
        .ser_push(ser_push), .ser_data(ser_data), .ser_err(ser_err), .ser_brk(ser_brk),
        .lb_push(lb_push), .lb_data(lb_data), .lb_brk(lb_brk), .pop(pop),
        .pop_data(pop_data), .pop_err(pop_err), .pop_brk(pop_brk),
        .full(full), .empty(empty), .free_cnt(free_cnt), .rx_irq(rx_irq),
        .stat_clr(stat_clr), .stat_err(stat_err), .stat_brk(stat_brk),
        .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata), .lvl_sel(lvl_sel)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    string mon_tag = "R2";

    // scoreboard model: entry = {brk, err[2:0], data[7:0]}
    logic [11:0] exp_q[$];
    logic        mode_m = 0, irq_m = 0, stat_known = 1;
    logic [3:0]  stat_m = 0;

    task automatic chk(string tag, bit ok, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor / model, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic        v;
            logic [11:0] ent;
            int          pre, dep;
            bit          push_ok, pop_ok;
            v   = lb_en ? lb_push : ser_push;
            ent = lb_en ? {lb_brk, 3'b000, lb_data} : {ser_brk, ser_err, ser_data};
            if (fifo_en != mode_m) begin
                exp_q.delete();
                mode_m = fifo_en;
            end else begin
                pre = exp_q.size();
                dep = mode_m ? DEPTH : 1;
                push_ok = v && pre < dep;
                pop_ok  = pop && pre > 0;
                if (pop) begin
                    if (pop_ok) begin
                        chk({mon_tag, " pop entry"}, {pop_brk, pop_err, pop_data} == exp_q[0],
                            int'({pop_brk, pop_err, pop_data}), int'(exp_q[0]));
                        stat_m = exp_q[0][11:8];
                        stat_known = 1;
                        void'(exp_q.pop_front());
                    end else stat_known = 0;
                end else if (stat_clr) begin
                    stat_m = 0;
                    stat_known = 1;
                end
                if (push_ok) exp_q.push_back(ent);
                if (pop && !push_ok && exp_q.size() + 1 == TRIG) irq_m = 0;
                else if (push_ok && !pop_ok && exp_q.size() == TRIG) irq_m = 1;
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk_state(string tag);
        int dep = mode_m ? DEPTH : 1;
        chk({tag, " full"}, full == (exp_q.size() == dep), full, exp_q.size() == dep);
        chk({tag, " empty"}, empty == (exp_q.size() == 0), empty, exp_q.size() == 0);
        chk({tag, " free"}, free_cnt == dep - exp_q.size(), free_cnt, dep - exp_q.size());
        chk({tag, " irq"}, rx_irq == irq_m, rx_irq, irq_m);
        if (stat_known)
            chk({tag, " status"}, {stat_brk, stat_err} == stat_m, {stat_brk, stat_err}, stat_m);
    endtask

    task automatic do_push(logic [7:0] d, logic [2:0] e, logic b);
        ser_push = 1; ser_data = d; ser_err = e; ser_brk = b;
        step();
        ser_push = 0; ser_brk = 0; ser_err = 0;
    endtask

    task automatic do_pop();
        pop = 1;
        step();
        pop = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 / R12 reset state
        chk_state("R1");
        chk("R12 lvl reset", lvl_sel == 6'h12, lvl_sel, 6'h12);
        lvl_wr = 1; lvl_wdata = 6'h2A; step(); lvl_wr = 0;
        chk("R12 lvl write", lvl_sel == 6'h2A, lvl_sel, 6'h2A);

        // R4 single-register mode, R6 set, R3 drop when full, R7 clear
        mon_tag = "R4";
        do_push(8'hA5, 3'd2, 0);
        chk_state("R4 R6 one push");
        do_push(8'h5A, 3'd1, 0);
        chk_state("R3 push on full single");
        do_pop();
        chk_state("R4 R7 R9 pop");

        // R5 switch to FIFO mode
        fifo_en = 1; step();
        chk_state("R5 enable");
        chk("R5 free16", free_cnt == 5'd16, free_cnt, 16);

        // R2 fill, R10 break entry, R3 overflow
        mon_tag = "R2";
        for (int i = 0; i < DEPTH; i++) begin
            do_push(8'h30 + 8'(i), 3'(i % 8), i == 5);
            chk_state("R2 fill");
        end
        do_push(8'hEE, 3'd7, 1);
        chk_state("R3 push on full fifo");
        mon_tag = "R10";
        for (int i = 0; i < DEPTH; i++) begin
            do_pop();
            chk_state("R2 R9 R10 drain");
        end

        // R8 pop on empty
        do_pop();
        chk_state("R8 pop empty");

        // R13 simultaneous push and pop
        mon_tag = "R13";
        do_push(8'h11, 3'd0, 0);
        ser_push = 1; ser_data = 8'h22; pop = 1; step(); ser_push = 0; pop = 0;
        chk_state("R13 push+pop");
        do_pop();
        chk_state("R13 tail");

        // R5 flush keeps irq, R7 empty pop clears it
        do_push(8'h01, 0, 0); do_push(8'h02, 0, 0); do_push(8'h03, 0, 0);
        chk_state("R6 three");
        fifo_en = 0; pop = 1; step(); pop = 0;
        chk_state("R5 flush");
        chk("R5 irq kept", rx_irq == 1'b1, rx_irq, 1);
        stat_known = 0;
        do_pop();
        chk_state("R7 empty pop");
        chk("R7 irq low", rx_irq == 1'b0, rx_irq, 0);

        // R11 loopback
        fifo_en = 1; step();
        lb_en = 1;
        do_push(8'h77, 3'd5, 0);
        chk_state("R11 serial ignored");
        lb_push = 1; lb_data = 8'h9C; lb_brk = 1;
        ser_push = 1; ser_err = 3'd6; step();
        lb_push = 0; lb_brk = 0; ser_push = 0; ser_err = 0;
        chk_state("R11 lb push");
        mon_tag = "R11";
        do_pop();
        chk_state("R11 R10 pop status");
        lb_en = 0;

        // R9 clear and pop-wins
        stat_clr = 1; step(); stat_clr = 0;
        chk_state("R9 clear");
        mon_tag = "R9";
        do_push(8'h44, 3'd3, 0);
        pop = 1; stat_clr = 1; step(); pop = 0; stat_clr = 0;
        chk_state("R9 pop wins");
        chk("R9 err latched", stat_err == 3'd3, stat_err, 3);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule